// File: doc/BRIEF.md
# USB2 PHY Power-Up Sequencer

This block brings a USB2 PHY out of reset and programs it without help from software. A one-cycle start request drives the PHY reset line high for a fixed hold time and then low. The block waits a longer settle time before it touches any PHY register. It then works through a fixed list of register accesses on a simple memory-mapped port: one masked read-modify-write, three PLL set-up writes, a PLL lock wait, a rewrite that takes the PLL out of reset, and five tuning writes. Every access is a valid/ready handshake. Each one waits for acceptance before the next step begins.

All delays are counted in clock cycles. The cycle counts are derived from the clock frequency parameter and from microsecond parameters. The block shows busy while it runs, pulses done when the last write is accepted, and leaves the PHY out of reset afterwards. A one-cycle stop request, in any state, puts the PHY back into reset and abandons the sequence.

Top module: `phy_boot_seq`

## Requirements
- R1: After reset: phy_rst_o is 1, busy_o is 0, done_o is 0, and rd_valid_o and wr_valid_o are both 0.
- R2: A start request in idle drives phy_rst_o to 1 with busy_o at 1 for exactly HOLD_US*T cycles, where T = max(1, CLK_FREQ_HZ/1e6). It then drives phy_rst_o to 0.
- R3: After the release, no access is made for exactly SETTLE_US*T cycles. The first access is then a single read at offset 0x54. No access is ever made while phy_rst_o is 1.
- R4: The first write goes to offset 0x54. It carries the read data with bit 2 cleared and all other bits kept.
- R5: The next three writes are, in order: 0x39400414 to 0x40, 0x927E0000 to 0x44, and 0xAC5F49E5 to 0x48.
- R6: After the 0x48 write is accepted, no access is made for exactly PLL_US*T cycles. The next write is 0x19400414 to 0x40, which clears bit 29 only.
- R7: The last five writes are, in order: 0xFE18 to 0x50, 0x08000FFF to 0x10, 0x34 to 0x0C, 0 to 0x38, and 0x78000 to 0x34.
- R8: A pending access holds its valid, address and data unchanged until ready is seen. The next access follows only after that. Read and write are never pending together, and wr_strb_o has all bits set.
- R9: done_o is 1 for exactly the one cycle after the last write is accepted. In that cycle busy_o falls and phy_rst_o stays 0. Exactly ten writes are made per run.
- R10: A start request while busy_o is 1 is ignored: the running sequence keeps its timing and its access list.
- R11: A stop request sets phy_rst_o to 1 and busy_o to 0 on the next cycle and drops any pending access. No further access follows. This holds from idle as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| stop_i | input | 1 | Stop request, one cycle |
| phy_rst_o | output | 1 | PHY reset, 1 = held in reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_valid_o | output | 1 | Read request pending |
| rd_ready_i | input | 1 | Read accepted, data valid |
| rd_addr_o | output | ADDR_W | Read byte offset |
| rd_data_i | input | 32 | Read data |
| wr_valid_o | output | 1 | Write request pending |
| wr_ready_i | input | 1 | Write accepted |
| wr_addr_o | output | ADDR_W | Write byte offset |
| wr_data_o | output | 32 | Write data |
| wr_strb_o | output | 4 | Byte lane enables |

## Verification
The hardest case to reach is the set of timing gaps that are not visible on any single port: the hold interval, the settle interval and the PLL wait. The bench measures each of them by counting the cycles in which busy is high with a given combination of reset level, valids and the number of writes accepted so far. The bench clock parameter is set to 1 MHz so the gaps stay short. The ready responder inserts a different number of stall cycles in each run. One run injects start requests in the middle of the settle interval and in the middle of the write list. Another run issues a stop right after the fifth write, so the bench can prove that nothing follows.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int DW       = 32;
  localparam int STEPS    = 10;
  localparam int IDX_W    = $clog2(STEPS);
  localparam int PLL_IDX  = 3;               // PLL wait follows this step
  localparam logic [7:0]    RMW_ADDR = 8'h54;
  localparam logic [DW-1:0] RMW_CLR  = 32'h0000_0004;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_SETTLE, S_READ, S_WRITE, S_PLL} state_e;

  typedef struct packed {
    logic [7:0]    addr;
    logic [DW-1:0] data;
  } step_t;

  function automatic step_t step_at(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    step_at = '{RMW_ADDR, 32'h0};      // data comes from rmw path
      4'd1:    step_at = '{8'h40, 32'h3940_0414};
      4'd2:    step_at = '{8'h44, 32'h927E_0000};
      4'd3:    step_at = '{8'h48, 32'hAC5F_49E5};
      4'd4:    step_at = '{8'h40, 32'h1940_0414};
      4'd5:    step_at = '{8'h50, 32'h0000_FE18};
      4'd6:    step_at = '{8'h10, 32'h0800_0FFF};
      4'd7:    step_at = '{8'h0C, 32'h0000_0034};
      4'd8:    step_at = '{8'h38, 32'h0000_0000};
      4'd9:    step_at = '{8'h34, 32'h0007_8000};
      default: step_at = '{8'h00, 32'h0};
    endcase
  endfunction
endpackage

// File: rtl/pbs_delay.sv
module pbs_delay #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] len_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == len_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || hit_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pbs_rmw.sv
module pbs_rmw #(
  parameter int          DW  = 32,
  parameter logic [DW-1:0] CLR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] rd_i,
  output logic [DW-1:0] wd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wd_o <= '0;
    else if (cap_i) wd_o <= rd_i & ~CLR;
  end
endmodule

// File: rtl/phy_boot_seq.sv
module phy_boot_seq
  import pbs_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int HOLD_US     = 1,
  parameter int SETTLE_US   = 1000,
  parameter int PLL_US      = 100,
  parameter int ADDR_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              phy_rst_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DW-1:0]     rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [DW/8-1:0]   wr_strb_o
);
  localparam int TICKS_US   = (CLK_FREQ_HZ >= 1_000_000) ? CLK_FREQ_HZ / 1_000_000 : 1;
  localparam int HOLD_CYC   = (HOLD_US   > 0) ? HOLD_US   * TICKS_US : 1;
  localparam int SETTLE_CYC = (SETTLE_US > 0) ? SETTLE_US * TICKS_US : 1;
  localparam int PLL_CYC    = (PLL_US    > 0) ? PLL_US    * TICKS_US : 1;
  localparam int MAX_CYC    = (HOLD_CYC > SETTLE_CYC)
                            ? ((HOLD_CYC > PLL_CYC) ? HOLD_CYC : PLL_CYC)
                            : ((SETTLE_CYC > PLL_CYC) ? SETTLE_CYC : PLL_CYC);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic             rst_q, done_q;
  logic             run, hit;
  logic [CNT_W-1:0] len;
  logic [DW-1:0]    rmw_data;
  step_t            step;

  assign step = step_at(idx_q);
  assign run  = (state_q == S_HOLD) || (state_q == S_SETTLE) || (state_q == S_PLL);

  always_comb begin
    case (state_q)
      S_HOLD:   len = CNT_W'(HOLD_CYC);
      S_SETTLE: len = CNT_W'(SETTLE_CYC);
      default:  len = CNT_W'(PLL_CYC);
    endcase
  end

  pbs_delay #(.W(CNT_W)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .len_i (len),
    .hit_o (hit)
  );

  pbs_rmw #(.DW(DW), .CLR(RMW_CLR)) u_rmw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (rd_valid_o && rd_ready_i),
    .rd_i  (rd_data_i),
    .wd_o  (rmw_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      rst_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (stop_i) begin
        state_q <= S_IDLE;
        idx_q   <= '0;
        rst_q   <= 1'b1;
      end else begin
        case (state_q)
          S_IDLE: if (start_i) begin
            state_q <= S_HOLD;
            idx_q   <= '0;
            rst_q   <= 1'b1;
          end
          S_HOLD: if (hit) begin
            state_q <= S_SETTLE;
            rst_q   <= 1'b0;
          end
          S_SETTLE: if (hit) state_q <= S_READ;
          S_READ:   if (rd_ready_i) state_q <= S_WRITE;
          S_WRITE: if (wr_ready_i) begin
            if (idx_q == IDX_W'(STEPS - 1)) begin
              state_q <= S_IDLE;
              idx_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              if (idx_q == IDX_W'(PLL_IDX)) state_q <= S_PLL;
            end
          end
          S_PLL:   if (hit) state_q <= S_WRITE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign phy_rst_o  = rst_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign rd_valid_o = (state_q == S_READ);
  assign rd_addr_o  = ADDR_W'(RMW_ADDR);
  assign wr_valid_o = (state_q == S_WRITE);
  assign wr_addr_o  = ADDR_W'(step.addr);
  assign wr_data_o  = (idx_q == '0) ? rmw_data : step.data;
  assign wr_strb_o  = '1;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic              phy_rst_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              rd_valid_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [31:0]       wr_data_o
);
  assert_stop_to_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> phy_rst_o && !busy_o && !rd_valid_o && !wr_valid_o);

  assert_hold_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i && !stop_i) |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_one_port_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o));

  assert_no_access_in_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o || wr_valid_o) |-> !phy_rst_o && busy_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !phy_rst_o);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !stop_i && !(wr_valid_o && wr_ready_i)) |=> busy_o);
endmodule

bind phy_boot_seq pbs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .phy_rst_o (phy_rst_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rd_valid_o(rd_valid_o),
  .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/sim_phy_boot_seq.sv
`timescale 1ns/1ps
module sim_phy_boot_seq;
  localparam int HOLD = 3, SETTLE = 1000, PLL = 100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic phy_rst, busy, done, rd_valid, rd_ready = 1'b0, wr_valid, wr_ready = 1'b0;
  logic [7:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic [3:0] wr_strb;
  logic [31:0] pre_g = '0;
  int lat_g = 0;

  always #5 clk = ~clk;

  assign rd_data = (rd_addr == 8'h54) ? pre_g : 32'h0;

  phy_boot_seq #(.CLK_FREQ_HZ(1_000_000), .HOLD_US(HOLD), .SETTLE_US(SETTLE),
                 .PLL_US(PLL), .ADDR_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .phy_rst_o(phy_rst), .busy_o(busy), .done_o(done),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_strb_o(wr_strb));

  int n_chk = 0, n_bad = 0;
  int cyc = 0, hold_cnt, settle_cnt, pll_cnt, rd_cnt, n_log, done_cnt, done_cyc, last_hs;
  int strb_bad, stab_bad;
  logic [7:0]  rd_addr_l;
  logic [7:0]  log_a [16];
  logic [31:0] log_d [16];
  logic prev_stall = 1'b0, prev_stop = 1'b0;
  logic [7:0] prev_a; logic [31:0] prev_d;
  logic [7:0] exp_a [10];
  logic [31:0] exp_d [10];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    hold_cnt = 0; settle_cnt = 0; pll_cnt = 0; rd_cnt = 0; n_log = 0;
    done_cnt = 0; done_cyc = -1; last_hs = -1; strb_bad = 0; stab_bad = 0;
  endtask

  // monitor: samples pre-edge values
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && phy_rst) hold_cnt++;
      if (busy && !phy_rst && !rd_valid && !wr_valid && n_log == 0 && rd_cnt == 0) settle_cnt++;
      if (busy && !rd_valid && !wr_valid && n_log == 4) pll_cnt++;
      if (prev_stall && !prev_stop && (!wr_valid || wr_addr != prev_a || wr_data != prev_d))
        stab_bad++;
      prev_stall = wr_valid && !wr_ready; prev_stop = stop;
      prev_a = wr_addr; prev_d = wr_data;
      if (rd_valid && rd_ready) begin rd_cnt++; rd_addr_l = rd_addr; end
      if (wr_valid && wr_ready) begin
        if (n_log < 16) begin log_a[n_log] = wr_addr; log_d[n_log] = wr_data; end
        n_log++;
        if (wr_strb != 4'hF) strb_bad++;
        last_hs = cyc;
      end
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
  end

  // ready responder with lat_g stall cycles
  int wc = 0, rc = 0;
  always @(negedge clk) begin
    if (wr_ready) wr_ready = 1'b0;
    else if (wr_valid) begin
      if (wc >= lat_g) begin wr_ready = 1'b1; wc = 0; end else wc++;
    end
    if (rd_ready) rd_ready = 1'b0;
    else if (rd_valid) begin
      if (rc >= lat_g) begin rd_ready = 1'b1; rc = 0; end else rc++;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 8000 && done_cnt == 0; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 phy_rst", phy_rst, 1); chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 valids", {rd_valid, wr_valid}, 0);
  endtask

  task automatic t_run(int lat, logic [31:0] pre, bit poke);
    clr_mon(); lat_g = lat; pre_g = pre;
    pulse_start();
    if (poke) begin
      repeat (400) @(negedge clk);
      pulse_start();                                   // R10 during settle
      for (int i = 0; i < 3000 && n_log < 7; i++) @(negedge clk);
      pulse_start();                                   // R10 during writes
    end
    wait_done();
    @(negedge clk);
    chk("R2 hold cycles", hold_cnt, HOLD);
    chk("R3 settle cycles", settle_cnt, SETTLE);
    chk("R3 single read", rd_cnt, 1);
    chk("R3 read addr", rd_addr_l, 8'h54);
    chk("R9 write count", n_log, 10);
    chk("R4 rmw addr", log_a[0], 8'h54);
    chk("R4 rmw data", log_d[0], pre & ~32'h4);
    for (int i = 1; i < 10; i++) begin
      chk(i < 4 ? "R5 pll addr" : (i == 4 ? "R6 unreset addr" : "R7 tune addr"), log_a[i], exp_a[i]);
      chk(i < 4 ? "R5 pll data" : (i == 4 ? "R6 unreset data" : "R7 tune data"), log_d[i], exp_d[i]);
    end
    chk("R6 pll wait", pll_cnt, PLL);
    chk("R9 done once", done_cnt, 1);
    chk("R9 done timing", done_cyc, last_hs + 1);
    chk("R9 idle after", {busy, phy_rst}, 2'b00);
    chk("R8 strobes", strb_bad, 0);
    chk("R8 stable while stalled", stab_bad, 0);
  endtask

  task automatic t_stop_mid();
    clr_mon(); lat_g = 1; pre_g = 32'h1234_5678;
    pulse_start();
    for (int i = 0; i < 3000 && n_log < 5; i++) @(negedge clk);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R11 reset on stop", phy_rst, 1);
    chk("R11 busy clear", busy, 0);
    chk("R11 access dropped", {rd_valid, wr_valid}, 0);
    repeat (300) @(negedge clk);
    chk("R11 no further writes", n_log, 5);
    chk("R11 no done", done_cnt, 0);
  endtask

  task automatic t_stop_idle();
    clr_mon();
    chk("R9 released before stop", phy_rst, 0);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R11 idle stop reset", phy_rst, 1);
    repeat (50) @(negedge clk);
    chk("R11 idle stop no access", n_log + rd_cnt, 0);
    chk("R11 idle stop busy", busy, 0);
  endtask

  initial begin
    exp_a[0] = 8'h54; exp_d[0] = 0;
    exp_a[1] = 8'h40; exp_d[1] = 32'h3940_0414;
    exp_a[2] = 8'h44; exp_d[2] = 32'h927E_0000;
    exp_a[3] = 8'h48; exp_d[3] = 32'hAC5F_49E5;
    exp_a[4] = 8'h40; exp_d[4] = 32'h1940_0414;
    exp_a[5] = 8'h50; exp_d[5] = 32'h0000_FE18;
    exp_a[6] = 8'h10; exp_d[6] = 32'h0800_0FFF;
    exp_a[7] = 8'h0C; exp_d[7] = 32'h0000_0034;
    exp_a[8] = 8'h38; exp_d[8] = 32'h0;
    exp_a[9] = 8'h34; exp_d[9] = 32'h0007_8000;
    clr_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run(0, 32'hFFFF_FFFF, 1'b0);
    t_run(3, 32'h0000_0004, 1'b0);
    t_run(1, 32'hA5A5_A5A5, 1'b1);
    t_stop_idle();
    t_stop_mid();
    t_run(2, 32'h0000_00F0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule